// File: doc/BRIEF.md
# Dual-Bank Clock Divider with Glitch-Free Output Gating

Each of the two banks in this block takes its own input clock. It can divide that clock by 1, 2 or 4 and sends the result to five output pairs. Each pair has a true output and a complement output. The division ratio and the enable both arrive as 2-bit codes taken from three-level pins: low, high or open. A per-bank format flag chooses how the complement output behaves. In differential mode it is the inverse of the true output. In single-ended CMOS mode it is an in-phase copy.

The enable is sampled on falling edges of the bank's input clock. It only reaches the output gate at a falling edge where the divided clock is low. An output pulse is therefore never cut short, and no pulse is ever started partway. A change of division ratio waits for the counter to wrap, so the clock period never shrinks during a switch. A disabled bank parks its outputs at a fixed level, and that level depends on the format flag.

Top module: `clkbank_dual`

## Requirements
- R1: While reset is asserted and after it is released, every true output is low and every complement output is at its parked level (see R8) until the bank is enabled.
- R2: Divider select code 2'b00 (pin low) divides by 2. Code 2'b01 (pin high) divides by 4. Codes 2'b10 (pin open) and 2'b11 divide by 1, so the output period is 1, 2 or 4 input periods.
- R3: In divide-by-2 and divide-by-4 the output is high for exactly half of its period.
- R4: Enable code 2'b00 (pin low) disables the bank. Codes 2'b01, 2'b10 (pin open) and 2'b11 enable it.
- R5: The enable is sampled on falling input edges. In divide-by-1, after the enable changes just after a rising edge, the new state is applied at the second falling edge: the first pulse after enabling rises after exactly two falling edges, and after disabling exactly one more pulse begins.
- R6: The gate only changes at a falling input edge where the divided clock is low, so every output high pulse has the full nominal width of its mode.
- R7: In divide-by-2 the first output pulse after enabling rises within 3 falling input edges; in divide-by-4 within 5. After disabling, at most 2 further pulses begin.
- R8: When disabled in differential mode (format flag 0), true outputs are low and complement outputs are high. When disabled in CMOS mode (format flag 1), both are low.
- R9: When enabled, all five true outputs of a bank are identical. Each complement is the inverse of its true output in differential mode and equal to it in CMOS mode.
- R10: A new divider select takes effect only when the divide counter wraps. The pulse in progress completes at its old width.
- R11: The two banks are independent: the clock, enable, select and format of one bank do not affect the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Bank A input clock |
| clk_b | input | 1 | Bank B input clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously per bank |
| oe_a_code | input | 2 | Bank A enable level code (00 low, 01 high, 10 open) |
| oe_b_code | input | 2 | Bank B enable level code |
| div_a_code | input | 2 | Bank A divider level code |
| div_b_code | input | 2 | Bank B divider level code |
| cmos_a | input | 1 | Bank A format: 1 single-ended CMOS, 0 differential |
| cmos_b | input | 1 | Bank B format |
| q_a | output | 5 | Bank A true outputs |
| qn_a | output | 5 | Bank A complement outputs |
| q_b | output | 5 | Bank B true outputs |
| qn_b | output | 5 | Bank B complement outputs |

## Verification
On every cycle the embedded properties check that the divide mode changes only at a counter wrap, that the divided clock toggles with a 50% pattern in both counting modes, that the gate holds while the divided clock is high, and that a closed gate gives the format-dependent parked levels. The bench scenarios cover the rest. They show the falling-edge count from an enable change to the first pulse, the number of pulses that still begin after a disable, the measured periods and high widths for every select code, and that a pulse in flight during a select change keeps its full width. Only the scenarios can show that the two banks do not interfere.

// File: rtl/clkbank_pkg.sv
`timescale 1ns/1ps
package clkbank_pkg;

  localparam int CNT_W = 2;

  localparam logic [1:0] LVL_LOW  = 2'b00;
  localparam logic [1:0] LVL_HIGH = 2'b01;
  localparam logic [1:0] LVL_OPEN = 2'b10;

  typedef enum logic [1:0] {
    DIV_BY1 = 2'd0,
    DIV_BY2 = 2'd1,
    DIV_BY4 = 2'd2
  } div_mode_e;

  // low -> /2, high -> /4, open (and the unused code) -> /1
  function automatic div_mode_e decode_div(input logic [1:0] code);
    case (code)
      LVL_LOW:  return DIV_BY2;
      LVL_HIGH: return DIV_BY4;
      default:  return DIV_BY1;
    endcase
  endfunction

  // terminal count of the phase counter in each mode
  function automatic logic [CNT_W-1:0] last_count(input div_mode_e mode);
    case (mode)
      DIV_BY2: return CNT_W'(1);
      DIV_BY4: return CNT_W'(3);
      default: return CNT_W'(0);
    endcase
  endfunction

  // only a pin pulled low disables; open counts as enabled
  function automatic logic decode_enable(input logic [1:0] code);
    return code != LVL_LOW;
  endfunction

endpackage

// File: rtl/clkbank_rst_sync.sv
`timescale 1ns/1ps
module clkbank_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_n;

  always_comb begin
    sync_n = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= '0;
    else          sync_q <= sync_n;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/clkbank_divider.sv
`timescale 1ns/1ps
module clkbank_divider
  import clkbank_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] div_code_i,
  output logic       div_clk_o,
  output logic       low_ok_o
);
  logic [CNT_W-1:0] cnt_q, cnt_n;
  div_mode_e        mode_q, mode_n;
  logic             phase_q, phase_n;
  logic             wrap;

  always_comb begin
    wrap   = (cnt_q == last_count(mode_q));
    cnt_n  = cnt_q + CNT_W'(1);
    mode_n = mode_q;
    if (wrap) begin
      cnt_n  = '0;
      mode_n = decode_div(div_code_i);
    end
    case (mode_n)
      DIV_BY2: phase_n = (cnt_n == '0);
      DIV_BY4: phase_n = !cnt_n[CNT_W-1];
      default: phase_n = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      mode_q  <= DIV_BY1;
      phase_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      mode_q  <= mode_n;
      phase_q <= phase_n;
    end
  end

  // divide-by-1 passes the source clock; the counting modes use a registered phase
  assign div_clk_o = (mode_q == DIV_BY1) ? clk_i : phase_q;
  assign low_ok_o  = (mode_q == DIV_BY1) || !phase_q;

  a_r10_mode_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != $past(mode_q)) |->
      ($past(cnt_q) == last_count(div_mode_e'($past(mode_q)))));

  a_r3_half_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == DIV_BY2 && $past(mode_q) == DIV_BY2) |-> (phase_q != $past(phase_q)));

  a_r3_quarter_pattern: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == DIV_BY4 && $past(mode_q) == DIV_BY4 && $past(mode_q, 2) == DIV_BY4)
      |-> (phase_q != $past(phase_q, 2)));
endmodule

// File: rtl/clkbank_gate.sv
`timescale 1ns/1ps
module clkbank_gate
  import clkbank_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] oe_code_i,
  input  logic       low_ok_i,
  output logic       gate_o
);
  logic oe_s_q, oe_s_n;
  logic gate_q, gate_n;

  always_comb begin
    oe_s_n = decode_enable(oe_code_i);
    gate_n = gate_q;
    if (low_ok_i) gate_n = oe_s_q;
  end

  // both stages sit on the falling edge of the source clock
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_s_q <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      oe_s_q <= oe_s_n;
      gate_q <= gate_n;
    end
  end

  assign gate_o = gate_q;

  a_r6_hold_while_high: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !low_ok_i |=> $stable(gate_q));
endmodule

// File: rtl/clkbank_bank.sv
`timescale 1ns/1ps
module clkbank_bank #(
  parameter int NUM_OUT    = 5,
  parameter int RST_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               arst_ni,
  input  logic [1:0]         oe_code_i,
  input  logic [1:0]         div_code_i,
  input  logic               fmt_cmos_i,
  output logic [NUM_OUT-1:0] q_o,
  output logic [NUM_OUT-1:0] qn_o
);
  logic rst_n;
  logic div_clk;
  logic low_ok;
  logic gate;
  logic gated;

  clkbank_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i   (clk_i),
    .arst_ni (arst_ni),
    .rst_no  (rst_n)
  );

  clkbank_divider u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .div_code_i (div_code_i),
    .div_clk_o  (div_clk),
    .low_ok_o   (low_ok)
  );

  clkbank_gate u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .oe_code_i (oe_code_i),
    .low_ok_i  (low_ok),
    .gate_o    (gate)
  );

  assign gated = div_clk & gate;

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_pair
    assign q_o[g]  = gated;
    assign qn_o[g] = fmt_cmos_i ? gated : ~gated;
  end

  a_r8_parked_levels: assert property (@(posedge clk_i) disable iff (!rst_n)
    !gate |-> (q_o == '0 && qn_o == (fmt_cmos_i ? '0 : '1)));
endmodule

// File: rtl/clkbank_dual.sv
`timescale 1ns/1ps
module clkbank_dual #(
  parameter int NUM_OUT    = 5,
  parameter int RST_STAGES = 2
) (
  input  logic               clk_a,
  input  logic               clk_b,
  input  logic               rst_n,
  input  logic [1:0]         oe_a_code,
  input  logic [1:0]         oe_b_code,
  input  logic [1:0]         div_a_code,
  input  logic [1:0]         div_b_code,
  input  logic               cmos_a,
  input  logic               cmos_b,
  output logic [NUM_OUT-1:0] q_a,
  output logic [NUM_OUT-1:0] qn_a,
  output logic [NUM_OUT-1:0] q_b,
  output logic [NUM_OUT-1:0] qn_b
);
  clkbank_bank #(.NUM_OUT(NUM_OUT), .RST_STAGES(RST_STAGES)) u_bank_a (
    .clk_i      (clk_a),
    .arst_ni    (rst_n),
    .oe_code_i  (oe_a_code),
    .div_code_i (div_a_code),
    .fmt_cmos_i (cmos_a),
    .q_o        (q_a),
    .qn_o       (qn_a)
  );

  clkbank_bank #(.NUM_OUT(NUM_OUT), .RST_STAGES(RST_STAGES)) u_bank_b (
    .clk_i      (clk_b),
    .arst_ni    (rst_n),
    .oe_code_i  (oe_b_code),
    .div_code_i (div_b_code),
    .fmt_cmos_i (cmos_b),
    .q_o        (q_b),
    .qn_o       (qn_b)
  );
endmodule

// File: tb/clkbank_dual_tb.sv
`timescale 1ns/1ps
module clkbank_dual_tb;
  logic clk_a = 1'b0;
  logic clk_b = 1'b0;
  always #2.5 clk_a = ~clk_a;
  always #3.5 clk_b = ~clk_b;

  logic       rst_n;
  logic [1:0] oe_a_code, oe_b_code, div_a_code, div_b_code;
  logic       cmos_a, cmos_b;
  logic [4:0] q_a, qn_a, q_b, qn_b;

  clkbank_dual u_dut (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
    .oe_a_code(oe_a_code), .oe_b_code(oe_b_code),
    .div_a_code(div_a_code), .div_b_code(div_b_code),
    .cmos_a(cmos_a), .cmos_b(cmos_b),
    .q_a(q_a), .qn_a(qn_a), .q_b(q_b), .qn_b(qn_b)
  );

  int checks   = 0;
  int failures = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint to_ps(input realtime t);
    return longint'(t * 1000.0);
  endfunction

  // vector table: select, format, enable code, high width ps, period ps, latency bound
  localparam int NV = 6;
  localparam logic [1:0] V_SEL  [NV] = '{2'b10, 2'b00, 2'b01, 2'b11, 2'b00, 2'b01};
  localparam logic       V_CMOS [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
  localparam logic [1:0] V_OE   [NV] = '{2'b01, 2'b10, 2'b11, 2'b01, 2'b01, 2'b10};
  localparam int         V_HI   [NV] = '{2500, 5000, 10000, 2500, 5000, 10000};
  localparam int         V_PER  [NV] = '{5000, 10000, 20000, 5000, 10000, 20000};
  localparam int         V_LAT  [NV] = '{2, 3, 5, 2, 3, 5};

  // edge counters and pulse-width monitor on bank A
  int      neg_cnt  = 0;
  int      rise_cnt = 0;
  bit      mon_en   = 1'b0;
  longint  exp_hi   = 0;
  longint  alt_hi   = 0;
  realtime t_rise   = 0.0;

  always @(negedge clk_a) neg_cnt++;
  always @(posedge q_a[0]) begin
    rise_cnt++;
    t_rise = $realtime;
  end
  always @(negedge q_a[0]) begin
    if (mon_en) begin
      longint w;
      w = to_ps($realtime - t_rise);
      chk(w == exp_hi || w == alt_hi, "R6", "pulse high width ps", w, exp_hi);
    end
  end

  task automatic check_parked_a(input string req);
    chk(q_a == 5'h00, req, "parked q_a", q_a, 0);
    chk(qn_a == (cmos_a ? 5'h00 : 5'h1f), req, "parked qn_a", qn_a, cmos_a ? 0 : 31);
  endtask

  initial begin
    #1_000_000;
    checks++;
    failures++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    realtime t0, t1, t2;
    int base, lat, rises;

    rst_n = 1'b0; oe_a_code = 2'b01; oe_b_code = 2'b01;
    div_a_code = 2'b10; div_b_code = 2'b10; cmos_a = 1'b0; cmos_b = 1'b0;

    // R1: parked during reset although enabled
    repeat (4) @(posedge clk_a);
    #1;
    check_parked_a("R1");
    chk(q_b == 5'h00 && qn_b == 5'h1f, "R1", "bank B reset q/qn", {q_b, qn_b}, 10'h01f);
    cmos_a = 1'b1;
    #0.5;
    check_parked_a("R8");
    cmos_a = 1'b0;

    // release with both banks disabled, stays parked (R1, R4)
    oe_a_code = 2'b00; oe_b_code = 2'b00;
    @(posedge clk_a); #1; rst_n = 1'b1;
    repeat (12) @(posedge clk_a);
    #1;
    check_parked_a("R1");
    chk(q_b == 5'h00, "R4", "bank B disabled q_b", q_b, 0);

    // vector walk over divider, format and enable codes
    for (int i = 0; i < NV; i++) begin
      div_a_code = V_SEL[i];
      cmos_a     = V_CMOS[i];
      exp_hi     = V_HI[i];
      alt_hi     = V_HI[i];
      repeat (12) @(posedge clk_a);
      #1;
      check_parked_a("R8");

      // enable latency (R4, R5, R7)
      @(posedge clk_a); #1;
      base = neg_cnt;
      oe_a_code = V_OE[i];
      @(posedge q_a[0]);
      lat = neg_cnt - base;
      if (V_SEL[i][1]) chk(lat == 2, "R5", "enable falling-edge latency", lat, 2);
      else chk(lat >= 2 && lat <= V_LAT[i], "R7", "enable falling-edge latency", lat, V_LAT[i]);
      mon_en = 1'b1;

      // period and duty (R2, R3)
      @(posedge q_a[0]); t0 = $realtime;
      @(negedge q_a[0]); t1 = $realtime;
      @(posedge q_a[0]); t2 = $realtime;
      chk(to_ps(t2 - t0) == V_PER[i], "R2", "output period ps", to_ps(t2 - t0), V_PER[i]);
      chk(to_ps(t1 - t0) == V_PER[i] / 2, "R3", "high time ps", to_ps(t1 - t0), V_PER[i] / 2);

      // running relationship of all pairs (R9)
      #1;
      chk(q_a == 5'h1f, "R9", "all true outputs high", q_a, 31);
      chk(qn_a == (V_CMOS[i] ? 5'h1f : 5'h00), "R9", "complement outputs", qn_a,
          V_CMOS[i] ? 31 : 0);

      // disable latency (R5, R7) then parked levels (R8)
      @(posedge clk_a); #1;
      base = rise_cnt;
      oe_a_code = 2'b00;
      repeat (12) @(posedge clk_a);
      rises = rise_cnt - base;
      if (V_SEL[i][1]) chk(rises == 1, "R5", "pulses begun after disable", rises, 1);
      else chk(rises <= 2, "R7", "pulses begun after disable", rises, 2);
      #1;
      check_parked_a("R8");
      @(negedge clk_a); #1;
      check_parked_a("R8");
    end

    // R10: select change mid-pulse from /4 to /1
    div_a_code = 2'b01; cmos_a = 1'b0; exp_hi = 10000; alt_hi = 10000;
    repeat (8) @(posedge clk_a);
    oe_a_code = 2'b10;
    repeat (16) @(posedge clk_a);
    @(posedge q_a[0]);
    t0 = $realtime;
    #1;
    exp_hi = 2500; alt_hi = 10000;
    div_a_code = 2'b10;
    #5;
    chk(q_a == 5'h1f, "R10", "pulse in flight still high", q_a, 31);
    repeat (10) @(posedge clk_a);
    alt_hi = 2500;
    @(posedge q_a[0]); t1 = $realtime;
    @(posedge q_a[0]); t2 = $realtime;
    chk(to_ps(t2 - t1) == 5000, "R10", "period after switch ps", to_ps(t2 - t1), 5000);
    oe_a_code = 2'b00;
    repeat (12) @(posedge clk_a);
    mon_en = 1'b0;

    // R11: bank B runs /2 on its own clock while bank A stays parked
    div_b_code = 2'b00; cmos_b = 1'b0;
    repeat (8) @(posedge clk_b);
    oe_b_code = 2'b11;
    repeat (12) @(posedge clk_b);
    @(posedge q_b[0]); t0 = $realtime;
    @(negedge q_b[0]); t1 = $realtime;
    @(posedge q_b[0]); t2 = $realtime;
    chk(to_ps(t2 - t0) == 14000, "R11", "bank B period ps", to_ps(t2 - t0), 14000);
    chk(to_ps(t1 - t0) == 7000, "R11", "bank B high time ps", to_ps(t1 - t0), 7000);
    #1;
    chk(qn_b == ~q_b, "R11", "bank B complement", qn_b, ~q_b);
    base = rise_cnt;
    repeat (10) @(posedge clk_a);
    #1;
    chk(rise_cnt == base, "R11", "bank A pulses while B runs", rise_cnt - base, 0);
    check_parked_a("R11");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule